// File: doc/BRIEF.md
# Sampling Event Counter With Threshold

This block watches a single hardware event line (for example, a last-level cache miss strobe) that may pulse once per clock cycle. It counts every pulse, whichever program is running, against a programmable sample-after threshold. Each time the count reaches that threshold, the block takes a snapshot of the instruction pointer presented at its input, the count value and a free-running 48-bit cycle timestamp. It places the snapshot in an eight-entry trace queue and raises a level interrupt.

The result is a statistical profile. All events of a sampling period are charged to whichever instruction pointer was live when the period closed. Software programs the threshold through a one-word configuration write, drains the trace queue through a first-word-fall-through read port, and clears the interrupt with an acknowledge strobe. A threshold of zero switches sampling off.

Top module: `evt_sampler`

## Requirements
- R1: After a synchronous reset, `irq_o`, `rd_valid_o` and `ovf_o` are 0 and the threshold is 0, so no sample fires until a nonzero threshold is written.
- R2: With threshold N (nonzero), every `evt_i` pulse is counted, whatever the value of `ip_i`. A sample fires in the cycle after the edge at which the N-th event of the period is counted. `irq_o` and the queued record appear at the following rising edge, and the record's count field equals N.
- R3: In the cycle a sample fires, the count restarts. An event present in that cycle is the first event of the next period, so under a continuous event stream samples are exactly N cycles apart.
- R4: A record holds the `ip_i` value present in the cycle the sample fired.
- R5: The timestamp is a 48-bit counter that is 0 after the last reset edge and adds 1 at every later rising edge. Neither sampling nor configuration writes disturb it. A record's timestamp field is its value in the firing cycle.
- R6: The trace queue holds up to 8 records in firing order. `rd_valid_o` is 1 while it is not empty, the oldest record is shown on the read outputs, and `rd_en_i` with `rd_valid_o` high removes it at the next edge.
- R7: A sample that fires while the queue holds 8 records and no record is being read in the same cycle is dropped, and `ovf_o` becomes 1 and stays 1 until reset. A read in the same cycle makes room, so the record is kept.
- R8: Writing the threshold with `cfg_we_i` clears the count at the same edge; events in the write cycle are not counted. While the threshold is 0, no sample fires and `irq_o` does not rise.
- R9: `irq_o` stays 1 from a sample until an edge with `irq_ack_i` high and no new sample firing. Samples that fire while it is already 1 are queued without any low gap on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event strobe, one event per high cycle |
| ip_i | input | 32 | Current instruction pointer |
| cfg_we_i | input | 1 | Threshold write enable |
| cfg_thr_i | input | 32 | Threshold value to write (0 disables) |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| rd_en_i | input | 1 | Remove the oldest trace record |
| irq_o | output | 1 | Level interrupt, pending sample |
| rd_valid_o | output | 1 | Trace queue not empty |
| rd_ip_o | output | 32 | Oldest record: instruction pointer |
| rd_cnt_o | output | 32 | Oldest record: count at sampling |
| rd_ts_o | output | 48 | Oldest record: timestamp |
| ovf_o | output | 1 | Sticky record-dropped flag |

## Verification
The bench targets the period boundary. It drives an event in the firing cycle and checks that periods stay exactly N events long: a design that discards that event or counts it twice produces records whose timestamps drift by one cycle. It fills the queue past eight records with and without a simultaneous read. A design that drops on a full-but-draining queue, or that overwrites the oldest record instead of dropping, shows up as a wrong record order or a wrong `ovf_o`. It also rewrites the threshold mid-period and holds the interrupt unacknowledged across several samples. A design that keeps the stale count fires early, and one that re-pulses the interrupt shows a low gap.

// File: rtl/evs_pkg.sv
package evs_pkg;
    // Default datapath widths shared by every part of the sampler.
    parameter int IP_W  = 32;
    parameter int CNT_W = 32;
    parameter int TS_W  = 48;

    // One captured sample.
    typedef struct packed {
        logic [IP_W-1:0]  ip;
        logic [CNT_W-1:0] cnt;
        logic [TS_W-1:0]  ts;
    } evs_rec_t;

    // Queue occupancy change for one cycle.
    typedef enum logic [1:0] {
        LVL_HOLD = 2'b00,
        LVL_DEC  = 2'b01,
        LVL_INC  = 2'b10,
        LVL_SWAP = 2'b11
    } lvl_op_e;

    function automatic lvl_op_e lvl_op(input logic push, input logic pop);
        return lvl_op_e'({push, pop});
    endfunction
endpackage

// File: rtl/evs_period_counter.sv
module evs_period_counter
    import evs_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt_i,
    input  logic         cfg_we_i,
    input  logic [W-1:0] cfg_thr_i,
    output logic         fire_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] thr_o
);
    logic [W-1:0] thr_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] evt_w;

    assign evt_w  = {{(W-1){1'b0}}, evt_i};
    assign fire_o = (thr_q != '0) && (cnt_q == thr_q);
    assign cnt_o  = cnt_q;
    assign thr_o  = thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            cnt_q <= '0;
        end else begin
            if (cfg_we_i) begin
                thr_q <= cfg_thr_i;
            end
            if (cfg_we_i || (thr_q == '0)) begin
                cnt_q <= '0;
            end else if (fire_o) begin
                cnt_q <= evt_w;
            end else begin
                cnt_q <= cnt_q + evt_w;
            end
        end
    end
endmodule

// File: rtl/evs_timebase.sv
module evs_timebase
    import evs_pkg::*;
#(
    parameter int W = TS_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] ts_o
);
    always_ff @(posedge clk) begin
        if (rst) ts_o <= '0;
        else     ts_o <= ts_o + 1'b1;
    end
endmodule

// File: rtl/evs_irq_ctl.sv
module evs_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    input  logic ack_i,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= fire_i | (irq_o & ~ack_i);
    end
endmodule

// File: rtl/evs_trace_fifo.sv
module evs_trace_fifo
    import evs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  evs_rec_t  rec_i,
    input  logic      pop_i,
    output evs_rec_t  head_o,
    output logic      valid_o,
    output logic      ovf_o,
    output logic [AW:0] level_o
);
    localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    evs_rec_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   level;
    logic          pop_ok, push_ok;

    assign pop_ok  = pop_i && (level != '0);
    assign push_ok = push_i && ((level != FULL_LVL) || pop_ok);
    assign valid_o = (level != '0);
    assign head_o  = mem[rd_ptr];
    assign level_o = level;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= rec_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf_o  <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= step_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
            case (lvl_op(push_ok, pop_ok))
                LVL_INC: level <= level + 1'b1;
                LVL_DEC: level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push_i && !push_ok) ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/evt_sampler.sv
module evt_sampler
    import evs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic [IP_W-1:0]  ip_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_thr_i,
    input  logic             irq_ack_i,
    input  logic             rd_en_i,
    output logic             irq_o,
    output logic             rd_valid_o,
    output logic [IP_W-1:0]  rd_ip_o,
    output logic [CNT_W-1:0] rd_cnt_o,
    output logic [TS_W-1:0]  rd_ts_o,
    output logic             ovf_o
);
    logic             fire;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic [TS_W-1:0]  ts_q;
    logic [AW:0]      fifo_level;
    evs_rec_t         snap, head;

    evs_period_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .evt_i(evt_i),
        .cfg_we_i(cfg_we_i), .cfg_thr_i(cfg_thr_i),
        .fire_o(fire), .cnt_o(cnt_q), .thr_o(thr_q)
    );

    evs_timebase #(.W(TS_W)) u_ts (
        .clk(clk), .rst(rst), .ts_o(ts_q)
    );

    evs_irq_ctl u_irq (
        .clk(clk), .rst(rst), .fire_i(fire), .ack_i(irq_ack_i), .irq_o(irq_o)
    );

    always_comb begin
        snap.ip  = ip_i;
        snap.cnt = cnt_q;
        snap.ts  = ts_q;
    end

    evs_trace_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(fire), .rec_i(snap), .pop_i(rd_en_i),
        .head_o(head), .valid_o(rd_valid_o), .ovf_o(ovf_o), .level_o(fifo_level)
    );

    assign rd_ip_o  = head.ip;
    assign rd_cnt_o = head.cnt;
    assign rd_ts_o  = head.ts;
endmodule

// File: rtl/evs_sampler_chk.sv
module evs_sampler_chk
    import evs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             evt,
    input logic             cfg_we,
    input logic             ack,
    input logic             rd_en,
    input logic             irq,
    input logic             rd_valid,
    input logic             ovf,
    input logic             fire,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] thr_q,
    input logic [AW:0]      level
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!irq && !rd_valid && !ovf));

    // R3
    period_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !cfg_we) |=> (cnt_q == {{(CNT_W-1){1'b0}}, $past(evt)}));

    // R6
    pop_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_valid && !fire) |=> (level == $past(level) - 1'b1));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((thr_q == '0) && !irq) |=> !irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);
endmodule

bind evt_sampler evs_sampler_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .evt(evt_i), .cfg_we(cfg_we_i), .ack(irq_ack_i),
    .rd_en(rd_en_i), .irq(irq_o), .rd_valid(rd_valid_o), .ovf(ovf_o),
    .fire(fire), .cnt_q(cnt_q), .thr_q(thr_q), .level(fifo_level)
);

// File: tb/sim_evt_sampler.sv
`timescale 1ns/1ps
module sim_evt_sampler;
    import evs_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             evt_i = 1'b0;
    logic [IP_W-1:0]  ip_i = '0;
    logic             cfg_we_i = 1'b0;
    logic [CNT_W-1:0] cfg_thr_i = '0;
    logic             irq_ack_i = 1'b0;
    logic             rd_en_i = 1'b0;
    logic             irq_o, rd_valid_o, ovf_o;
    logic [IP_W-1:0]  rd_ip_o;
    logic [CNT_W-1:0] rd_cnt_o;
    logic [TS_W-1:0]  rd_ts_o;

    evt_sampler #(.DEPTH(8)) u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .ip_i(ip_i),
        .cfg_we_i(cfg_we_i), .cfg_thr_i(cfg_thr_i), .irq_ack_i(irq_ack_i),
        .rd_en_i(rd_en_i), .irq_o(irq_o), .rd_valid_o(rd_valid_o),
        .rd_ip_o(rd_ip_o), .rd_cnt_o(rd_cnt_o), .rd_ts_o(rd_ts_o), .ovf_o(ovf_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Expected-behaviour model state
    logic [CNT_W-1:0] m_thr, m_cnt;
    logic [TS_W-1:0]  m_ts;
    logic             m_irq, m_ovf;
    evs_rec_t         mq[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_outputs();
        chk("R9 irq_o", 64'(irq_o), 64'(m_irq));
        chk("R6 rd_valid_o", 64'(rd_valid_o), 64'(mq.size() != 0));
        chk("R7 ovf_o", 64'(ovf_o), 64'(m_ovf));
        if (mq.size() != 0 && rd_valid_o) begin
            chk("R4 rd_ip_o", 64'(rd_ip_o), 64'(mq[0].ip));
            chk("R2 rd_cnt_o", 64'(rd_cnt_o), 64'(mq[0].cnt));
            chk("R5 rd_ts_o", 64'(rd_ts_o), 64'(mq[0].ts));
        end
    endtask

    // One cycle: entered at a falling edge, left at the next falling edge.
    task automatic step(input logic e, input logic [IP_W-1:0] ip, input logic we,
                        input logic [CNT_W-1:0] wd, input logic ack, input logic rd);
        logic fire, pop, keep;
        evs_rec_t r;
        compare_outputs();
        evt_i = e; ip_i = ip; cfg_we_i = we; cfg_thr_i = wd;
        irq_ack_i = ack; rd_en_i = rd;
        fire = (m_thr != 0) && (m_cnt == m_thr);
        pop  = rd && (mq.size() != 0);
        keep = fire && ((mq.size() < 8) || pop);
        r.ip = ip; r.cnt = m_cnt; r.ts = m_ts;
        @(posedge clk);
        if (we || m_thr == 0) m_cnt = '0;
        else if (fire)        m_cnt = CNT_W'(e);
        else                  m_cnt = m_cnt + CNT_W'(e);
        if (we) m_thr = wd;
        m_irq = fire | (m_irq & ~ack);
        if (fire && !keep) m_ovf = 1'b1;
        if (pop)  void'(mq.pop_front());
        if (keep) mq.push_back(r);
        m_ts = m_ts + 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        evt_i = 0; cfg_we_i = 0; irq_ack_i = 0; rd_en_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_thr = '0; m_cnt = '0; m_ts = '0; m_irq = 0; m_ovf = 0;
        mq.delete();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [TS_W-1:0] ts_prev;
        int n;
        void'($urandom(32'd20240611));

        // R1: reset state and default-disabled threshold
        do_reset();
        chk("R1 irq_o after reset", 64'(irq_o), 0);
        chk("R1 rd_valid_o after reset", 64'(rd_valid_o), 0);
        chk("R1 ovf_o after reset", 64'(ovf_o), 0);
        for (int i = 0; i < 20; i++) step(1'b1, 32'(i), 1'b0, '0, 1'b0, 1'b0);
        chk("R1 no sample with default threshold", 64'(rd_valid_o | irq_o), 0);

        // R2/R3/R5: continuous events, threshold 3
        step(1'b0, '0, 1'b1, 32'd3, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) step(1'b1, 32'(100 + i), 1'b0, '0, 1'b0, 1'b0);
        idle(3);
        n = 0;
        ts_prev = '0;
        while (rd_valid_o && n < 20) begin
            chk("R2 record count equals threshold", 64'(rd_cnt_o), 3);
            if (n > 0) chk("R3 samples three cycles apart", 64'(rd_ts_o - ts_prev), 3);
            ts_prev = rd_ts_o;
            step(1'b0, '0, 1'b0, '0, 1'b1, 1'b1);
            n++;
        end
        chk("R2 three samples from nine events", 64'(n), 3);

        // R8: rewriting the threshold clears the count
        step(1'b0, '0, 1'b1, 32'd5, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 32'hA0, 1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 32'hA1, 1'b1, 32'd5, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 32'hB0, 1'b0, '0, 1'b0, 1'b0);
        idle(2);
        chk("R8 count cleared by threshold write", 64'(rd_valid_o), 0);
        step(1'b1, 32'hB1, 1'b0, '0, 1'b0, 1'b0);
        step(1'b0, 32'hC7, 1'b0, '0, 1'b0, 1'b0);
        chk("R8 fires on fifth event after rewrite", 64'(rd_valid_o), 1);
        chk("R4 captured ip of firing cycle", 64'(rd_ip_o), 64'h0C7);
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b1);

        // R7/R9: overflow with irq never acknowledged
        step(1'b0, '0, 1'b1, 32'd1, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 32'(200 + i), 1'b0, '0, 1'b0, 1'b0);
            if (i > 2) chk("R9 irq held across samples", 64'(irq_o), 1);
        end
        chk("R7 overflow flag set", 64'(ovf_o), 1);
        step(1'b0, '0, 1'b1, 32'd0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        chk("R9 irq cleared by ack", 64'(irq_o), 0);
        n = 0;
        while (rd_valid_o && n < 20) begin
            step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
            n++;
        end
        chk("R6 queue held eight records", 64'(n), 8);
        chk("R7 overflow stays set", 64'(ovf_o), 1);

        // R7: full queue with read in the same cycle keeps the sample
        step(1'b0, '0, 1'b1, 32'd1, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 32'(300 + i), 1'b0, '0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b1, 32'(400 + i), 1'b0, '0, 1'b1, 1'b1);
        step(1'b0, '0, 1'b1, 32'd0, 1'b1, 1'b0);
        idle(1);

        // R1: reset clears the sticky flag
        do_reset();
        chk("R1 ovf_o cleared by reset", 64'(ovf_o), 0);

        // Random traffic with model comparison every cycle (R2..R9)
        for (int i = 0; i < 6000; i++) begin
            logic e, we, ack, rd;
            logic [CNT_W-1:0] wd;
            e   = ($urandom_range(0, 99) < 45);
            we  = ($urandom_range(0, 99) < 2);
            wd  = CNT_W'($urandom_range(0, 6));
            ack = ($urandom_range(0, 99) < 15);
            rd  = ($urandom_range(0, 99) < 20);
            step(e, IP_W'($urandom), we, wd, ack, rd);
        end
        compare_outputs();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule